// File: doc/BRIEF.md
# Circular Log Memory Write Manager

This block turns a stream of already-selected access records into word writes into a storage region in memory. Software gives the region as an inclusive pair of word addresses, a base and a limit. The block keeps a pointer to the next free word and drives each incoming record to memory at that pointer. After every write that completes, the pointer moves forward by one word.

When a write lands on or past the limit, the block acts according to a policy input. With wrap on, the pointer returns to the base, so the oldest records are overwritten next. With wrap off, the pointer freezes and every later record is swallowed without a memory write. Both cases raise a sticky overflow flag. Software moves the pointer back to the base with a one-cycle reload strobe. It drops the flag with a separate one-cycle clear strobe.

Records arrive on a valid/ready stream, and writes leave on a valid/ready memory port. Back-pressure passes straight through: while the block is writing, `rec_ready` equals `mem_wr_ready`. A record moves only in a cycle where both valid and ready are high. Once the pointer has frozen, `rec_ready` is held high so that the producer never stalls on dropped records.

Top module: `logring_writer`

## Requirements
- R1: During and after reset, before any record arrives, `cur_addr` is 0, `ovf_flag` is 0 and `mem_wr_valid` is 0.
- R2: When not frozen, `mem_wr_valid` equals `rec_valid`, `mem_wr_addr` equals `cur_addr`, `mem_wr_data` equals `rec_data`, and `rec_ready` equals `mem_wr_ready`. A record transfers in a cycle with `rec_valid` and `mem_wr_ready` both high.
- R3: A cycle with `ptr_reload` high makes `cur_addr` equal `cfg_base` on the next cycle and unfreezes the block.
- R4: A transfer at an address below `cfg_limit` (unsigned) advances `cur_addr` by 4 on the next cycle.
- R5: With `cfg_wrap_en` = 1, a transfer at an address at or above `cfg_limit` still writes, then sets `cur_addr` to `cfg_base` and sets `ovf_flag`.
- R6: With `cfg_wrap_en` = 0, a transfer at an address at or above `cfg_limit` still writes, then holds `cur_addr`, sets `ovf_flag` and freezes the block. While frozen, `rec_ready` is 1 and `mem_wr_valid` is 0, and each valid record is discarded and sets `ovf_flag` again.
- R7: `ovf_flag` stays set until a cycle with `ovf_clear` high, after which it reads 0 if no new overflow occurred in that cycle.
- R8: If `ovf_clear` and an overflow event fall in the same cycle, `ovf_flag` is 1 afterwards.
- R9: If `ptr_reload` and a transfer fall in the same cycle, the write goes to the old address and `cur_addr` becomes `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Record stream valid |
| rec_ready | output | 1 | Record stream ready |
| rec_data | input | 32 | Record word |
| mem_wr_valid | output | 1 | Memory write request valid |
| mem_wr_ready | input | 1 | Memory write request ready |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write word |
| cfg_base | input | 32 | First word address of the region |
| cfg_limit | input | 32 | Last word address of the region |
| cfg_wrap_en | input | 1 | 1 = wrap and overwrite, 0 = freeze at limit |
| ptr_reload | input | 1 | Strobe: pointer takes base |
| ovf_clear | input | 1 | Strobe: clear overflow flag |
| cur_addr | output | 32 | Address of the next write |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The embedded assertions check four things on every cycle: that a reload lands on the base, that an ordinary write steps the pointer by one word, that a wrap returns the pointer to the base, and that a frozen block never drives a memory write while still accepting records. They also check that the flag holds without a clear and that an overflow event always leaves it set. The bench's scenarios are needed for the rest. These are the exact cycle in which the freeze begins, the collisions of reload with a write and of clear with a drop, the path of stalled memory handshakes, and long mixed runs with switching policy. In every one of them the whole port state is compared with a behavioural model.

// File: rtl/logring_pkg.sv
package logring_pkg;

  // How the pointer moves after a cycle
  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_STEP = 2'd1,
    ADV_WRAP = 2'd2,
    ADV_HALT = 2'd3
  } adv_e;

  // Decide the pointer move for one completed write
  function automatic adv_e pick_adv(input logic at_end, input logic wrap_en);
    if (!at_end)     return ADV_STEP;
    else if (wrap_en) return ADV_WRAP;
    else             return ADV_HALT;
  endfunction

endpackage

// File: rtl/logring_port.sv
module logring_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [DW-1:0] rec_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          halted,
  input  logic [AW-1:0] ptr,
  output logic          wr_fire,
  output logic          drop_fire
);

  // While frozen, records are swallowed; otherwise ready mirrors memory
  always_comb begin
    mem_wr_valid = rec_valid && !halted;
    mem_wr_addr  = ptr;
    mem_wr_data  = rec_data;
    rec_ready    = halted ? 1'b1 : mem_wr_ready;
    wr_fire      = mem_wr_valid && mem_wr_ready;
    drop_fire    = rec_valid && halted;
  end

endmodule

// File: rtl/logring_ptr.sv
module logring_ptr
  import logring_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic          cfg_wrap_en,
  input  logic          ptr_reload,
  input  logic          wr_fire,
  input  logic          drop_fire,
  output logic [AW-1:0] ptr,
  output logic          halted,
  output logic          ovf_evt
);

  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic  at_end;
  adv_e  adv;
  logic [AW-1:0] ptr_nxt;
  logic          halted_nxt;

  always_comb begin
    at_end = (ptr >= cfg_limit);
    adv    = wr_fire ? pick_adv(at_end, cfg_wrap_en) : ADV_NONE;
    ovf_evt = drop_fire || (wr_fire && at_end);
    ptr_nxt    = ptr;
    halted_nxt = halted;
    case (adv)
      ADV_STEP: ptr_nxt = ptr + STEP;
      ADV_WRAP: ptr_nxt = cfg_base;
      ADV_HALT: halted_nxt = 1'b1;
      default:  ;
    endcase
    // reload has priority over any move from a write
    if (ptr_reload) begin
      ptr_nxt    = cfg_base;
      halted_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      halted <= 1'b0;
    end else begin
      ptr    <= ptr_nxt;
      halted <= halted_nxt;
    end
  end

  // R3 / R9: reload lands on the base, even alongside a write
  p_reload_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reload |=> (ptr == $past(cfg_base)) && !halted);

  // R4: ordinary write steps one word
  p_step_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ptr_reload && (ptr < cfg_limit)) |=> ptr == $past(ptr) + STEP);

  // R5: wrap returns to base
  p_wrap_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ptr_reload && cfg_wrap_en && (ptr >= cfg_limit)) |=> ptr == $past(cfg_base));

  // R6: frozen pointer stays put until reload
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ptr_reload) |=> halted && $stable(ptr));

endmodule

// File: rtl/logring_flag.sv
module logring_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic ovf_clear,
  output logic ovf_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_flag <= 1'b0;
    else if (ovf_evt)    ovf_flag <= 1'b1;
    else if (ovf_clear)  ovf_flag <= 1'b0;
  end

  // R7: sticky without a clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  // R8: overflow beats clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

endmodule

// File: rtl/logring_writer.sv
module logring_writer #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [DW-1:0] rec_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic          cfg_wrap_en,
  input  logic          ptr_reload,
  input  logic          ovf_clear,
  output logic [AW-1:0] cur_addr,
  output logic          ovf_flag
);

  logic halted, wr_fire, drop_fire, ovf_evt;

  logring_port #(.AW(AW), .DW(DW)) u_port (
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_data     (rec_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .halted       (halted),
    .ptr          (cur_addr),
    .wr_fire      (wr_fire),
    .drop_fire    (drop_fire)
  );

  logring_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_base    (cfg_base),
    .cfg_limit   (cfg_limit),
    .cfg_wrap_en (cfg_wrap_en),
    .ptr_reload  (ptr_reload),
    .wr_fire     (wr_fire),
    .drop_fire   (drop_fire),
    .ptr         (cur_addr),
    .halted      (halted),
    .ovf_evt     (ovf_evt)
  );

  logring_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_evt   (ovf_evt),
    .ovf_clear (ovf_clear),
    .ovf_flag  (ovf_flag)
  );

  // R6: frozen block accepts but never writes
  p_frozen_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_wr_valid && rec_ready));

  // R1: clean state right after reset release
  p_reset_clean_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cur_addr == '0) && !ovf_flag);

endmodule

// File: tb/logring_writer_tb_top.sv
`timescale 1ns/1ps
module logring_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0, rec_ready;
  logic [31:0] rec_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic        cfg_wrap_en = 1'b1, ptr_reload = 1'b0, ovf_clear = 1'b0;
  logic [31:0] cur_addr;
  logic        ovf_flag;

  always #2.5 clk = ~clk;

  logring_writer dut_i (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_wrap_en(cfg_wrap_en),
    .ptr_reload(ptr_reload), .ovf_clear(ovf_clear),
    .cur_addr(cur_addr), .ovf_flag(ovf_flag)
  );

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  logic [31:0] m_cur = '0;
  bit          m_flag = 0, m_frozen = 0;
  string       ptr_tag = "R1", flag_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t = m_frozen ? "R6" : "R2";
    chk(t, "mem_wr_valid", 32'(mem_wr_valid), 32'(rec_valid && !m_frozen));
    chk(t, "rec_ready", 32'(rec_ready), 32'(m_frozen ? 1'b1 : mem_wr_ready));
    if (rec_valid && !m_frozen) begin
      chk(t, "mem_wr_addr", mem_wr_addr, m_cur);
      chk(t, "mem_wr_data", mem_wr_data, rec_data);
    end
    chk(ptr_tag, "cur_addr", cur_addr, m_cur);
    chk(flag_tag, "ovf_flag", 32'(ovf_flag), 32'(m_flag));
  endtask

  task automatic model_edge();
    bit wr = rec_valid && mem_wr_ready && !m_frozen;
    bit evt = 0;
    logic [31:0] nc = m_cur;
    bit nf = m_frozen;
    ptr_tag = ptr_tag;
    if (wr) begin
      if (m_cur >= cfg_limit) begin
        evt = 1;
        if (cfg_wrap_en) begin nc = cfg_base; ptr_tag = "R5"; end
        else begin nf = 1; ptr_tag = "R6"; end
      end else begin
        nc = m_cur + 32'd4; ptr_tag = "R4";
      end
    end
    if (rec_valid && m_frozen) evt = 1;
    if (ptr_reload) begin nc = cfg_base; nf = 0; ptr_tag = wr ? "R9" : "R3"; end
    if (evt) begin
      flag_tag = ovf_clear ? "R8" : (cfg_wrap_en ? "R5" : "R6");
      m_flag = 1;
    end else if (ovf_clear) begin
      flag_tag = "R7"; m_flag = 0;
    end
    m_cur = nc;
    m_frozen = nf;
  endtask

  task automatic cyc(bit v, logic [31:0] d, bit r, bit rl, bit cl);
    @(negedge clk);
    rec_valid = v; rec_data = d; mem_wr_ready = r; ptr_reload = rl; ovf_clear = cl;
    #1 compare_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    #1 begin
      // R1: state held in reset
      chk("R1", "cur_addr in reset", cur_addr, 32'h0);
      chk("R1", "ovf_flag in reset", 32'(ovf_flag), 32'h0);
      chk("R1", "mem_wr_valid in reset", 32'(mem_wr_valid), 32'h0);
    end
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);  // R1 after release

    // loop mode, four-word region
    cfg_base = 32'h100; cfg_limit = 32'h10C; cfg_wrap_en = 1;
    cyc(0, 0, 0, 1, 0);                  // R3 reload
    for (int i = 0; i < 6; i++) cyc(1, 32'hA000 + i, 1, 0, 0);  // R4, R5 wrap
    cyc(1, 32'hBEEF, 0, 0, 0);           // R2 stall
    cyc(1, 32'hBEEF, 0, 0, 0);
    cyc(1, 32'hBEEF, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 1);                  // R7 clear
    cyc(0, 0, 1, 0, 0);

    // non-loop mode: freeze at limit
    cfg_wrap_en = 0;
    cyc(0, 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc(1, 32'hC000 + i, 1, 0, 0);  // R6
    cyc(1, 32'hD1, 0, 0, 0);             // R6 dropped, ready high while memory stalls
    cyc(0, 0, 0, 0, 1);                  // R7 clear while frozen
    cyc(0, 0, 0, 0, 0);
    cyc(1, 32'hD2, 1, 0, 1);             // R8 drop vs clear
    cyc(0, 0, 1, 0, 0);
    cyc(1, 32'hD3, 1, 1, 0);             // R3 reload while frozen
    cyc(1, 32'hE0, 1, 0, 0);
    cyc(1, 32'hE1, 1, 1, 0);             // R9 reload beats write
    cyc(0, 0, 1, 0, 0);

    // mixed pseudo-random traffic
    cfg_limit = 32'h118;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:4] == 6'd0) cfg_wrap_en = ~cfg_wrap_en;
      cyc(lfsr[0] | lfsr[5], {16'h5A5A, lfsr}, lfsr[1] | lfsr[7],
          lfsr[8:2] == 7'd3, lfsr[6:2] == 5'd9);
    end
    finish_run();
  end

endmodule